// File: doc/BRIEF.md
# Cascadable Column Data Capture

This block is the digital front end of a flat-panel column driver. On every shift clock it takes three 6-bit gray-scale dots, packed into one 18-bit word, and writes them into a 240-entry data register. The three entries it writes are chosen by a pointer that a start pulse sets in motion. The pointer advances by three channels per clock, so a full line takes 80 clocks. It can run from the low channel end or from the high channel end.

Two start ports, one on each side, exchange the input and output roles when the direction select changes. This lets several devices be chained into one long column. On its 80th clock a device raises a one-clock carry pulse, which starts the next device in the chain.

A rising edge on the strobe input copies the whole data register into an output latch of 240 six-bit codes and returns the pointer to idle. A device ignores start pulses after power-up until it has seen its first strobe.

Top module: `column_capture`

## Requirements
- R1: After the asynchronous active-low reset, all 240 latch codes are zero and both start-port outputs are low.
- R2: Until the first strobe rising edge after reset, start pulses are ignored: no channel is written and no carry is raised.
- R3: With dirRight=1, the start input is startRIn. The clock edge that sees the start pulse writes group 0. Group g (g = 0..79, one per clock) stores pixIn[5:0] in channel index 3g, pixIn[11:6] in 3g+1 and pixIn[17:12] in 3g+2. Channel index k is latchOut[6k+5:6k].
- R4: With dirRight=0, the start input is startLIn. Group g stores pixIn[5:0] in channel index 239-3g, pixIn[11:6] in 238-3g and pixIn[17:12] in 237-3g.
- R5: With dirRight=1, startLOe=1 and startROe=0, and startROut stays 0. With dirRight=0, startROe=1 and startLOe=0, and startLOut stays 0.
- R6: The carry output on the enabled port goes high after the 80th clock of a line, which is the edge that writes group 79. It is high for exactly one clock and is low on the clock before.
- R7: Once a line's 80 clocks are complete, further shift clocks without a new start pulse leave the data register unchanged.
- R8: On a strobe rising edge the latch takes the data register contents. The latch does not change at any other time, including while the strobe is held high.
- R9: A strobe returns the pointer to idle, even in the middle of a line. Later clocks write nothing until a new start pulse arrives, and that pulse begins again at group 0.
- R10: A start pulse that arrives while a line is in progress is ignored: the line continues at its current group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| dirRight | input | 1 | Fill direction: 1 runs from low to high channel index, 0 runs from high to low |
| pixIn | input | 18 | Three 6-bit dots per clock |
| strobe | input | 1 | Latch strobe, acts on its rising edge |
| startRIn | input | 1 | Right-side start port, input value |
| startROut | output | 1 | Right-side start port, output value |
| startROe | output | 1 | Right-side start port, output enable |
| startLIn | input | 1 | Left-side start port, input value |
| startLOut | output | 1 | Left-side start port, output value |
| startLOe | output | 1 | Left-side start port, output enable |
| latchOut | output | 1440 | 240 six-bit latched codes, channel k at bits 6k+5:6k |

## Verification
The data words differ per group and per dot lane, so a wrong lane order, a group written to the wrong place or a reversed direction shows up as a code mismatch in the latch. Full forward and reverse lines are checked against a model of the channel mapping, and the carry is sampled on the clocks just before, at and after the 80th on both ports. Clocks run past the end of a line, lines cut short by a strobe, a repeated start in mid-line and a strobe held high across a whole line each test one rule for when a write or latch copy must not happen. A line with no strobe yet since reset confirms that the device stays dormant before its first strobe.

// File: rtl/column_pkg.sv
`timescale 1ns/1ps
package column_pkg;
  localparam int CH_COUNT = 240;
  localparam int DOT_BITS = 6;
  localparam int DOTS     = 3;
  localparam int STEPS    = CH_COUNT / DOTS;
  localparam int GROUP_W  = $clog2(STEPS);

  typedef struct packed {
    logic               write;
    logic [GROUP_W-1:0] group;
    logic               snap;
  } ctrl_t;
endpackage

// File: rtl/column_ctrl.sv
`timescale 1ns/1ps
module column_ctrl
  import column_pkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  startIn,
  input  logic  strobe,
  output ctrl_t c,
  output logic  carry
);
  localparam logic [GROUP_W-1:0] LAST = GROUP_W'(STEPS - 1);

  logic active;
  logic armed;
  logic strobeQ;
  logic [GROUP_W-1:0] count;

  always_comb begin
    c.snap  = strobe && !strobeQ;
    c.write = armed && !c.snap && (active || startIn);
    c.group = active ? count : '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active  <= 1'b0;
      armed   <= 1'b0;
      strobeQ <= 1'b0;
      count   <= '0;
      carry   <= 1'b0;
    end else begin
      strobeQ <= strobe;
      carry   <= 1'b0;
      if (c.snap) begin
        active <= 1'b0;
        count  <= '0;
        armed  <= 1'b1;
      end else if (c.write) begin
        if (c.group == LAST) begin
          active <= 1'b0;
          count  <= '0;
          carry  <= 1'b1;
        end else begin
          active <= 1'b1;
          count  <= c.group + 1'b1;
        end
      end
    end
  end

  // R6: carry pulse lasts one clock only
  a_r6_carry_single: assert property (@(posedge clk) disable iff (!rstN)
    carry |=> !carry);
  // R6: carry rises only after the final group was written
  a_r6_carry_after_last: assert property (@(posedge clk) disable iff (!rstN)
    $rose(carry) |-> $past(c.write && c.group == LAST));
  // R9: after a strobe the pointer is back at group 0
  a_r9_strobe_idles: assert property (@(posedge clk) disable iff (!rstN)
    c.snap |=> (c.group == '0));
  // R2: no write before the first strobe
  a_r2_unarmed: assert property (@(posedge clk) disable iff (!rstN)
    !armed |-> !c.write);
endmodule

// File: rtl/column_datapath.sv
`timescale 1ns/1ps
module column_datapath
  import column_pkg::*;
#(
  parameter int CHANNELS = CH_COUNT,
  parameter int BITS     = DOT_BITS,
  parameter int LANES    = DOTS
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       dirRight,
  input  logic [LANES*BITS-1:0]      pixIn,
  input  ctrl_t                      c,
  output logic [CHANNELS*BITS-1:0]   latchFlat
);
  localparam int GROUPS = CHANNELS / LANES;

  for (genvar k = 0; k < CHANNELS; k++) begin : g_ch
    localparam int FWD_G = k / LANES;
    localparam int FWD_S = k % LANES;
    localparam int REV_G = (CHANNELS - 1 - k) / LANES;
    localparam int REV_S = (CHANNELS - 1 - k) % LANES;

    logic            hit;
    logic [BITS-1:0] val;
    logic [BITS-1:0] dataQ;
    logic [BITS-1:0] latchQ;

    assign hit = c.write && (dirRight ? (c.group == GROUP_W'(FWD_G))
                                      : (c.group == GROUP_W'(REV_G)));
    assign val = dirRight ? pixIn[FWD_S*BITS +: BITS] : pixIn[REV_S*BITS +: BITS];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataQ  <= '0;
        latchQ <= '0;
      end else begin
        if (hit)    dataQ  <= val;
        if (c.snap) latchQ <= dataQ;
      end
    end

    assign latchFlat[k*BITS +: BITS] = latchQ;
  end

  // R8: latch holds unless a strobe edge was seen
  a_r8_latch_hold: assert property (@(posedge clk) disable iff (!rstN)
    !c.snap |=> $stable(latchFlat));
  // R3: pointer never leaves the line
  a_r3_group_range: assert property (@(posedge clk) disable iff (!rstN)
    c.write |-> (int'(c.group) < GROUPS));
endmodule

// File: rtl/column_capture.sv
`timescale 1ns/1ps
module column_capture
  import column_pkg::*;
(
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         dirRight,
  input  logic [DOTS*DOT_BITS-1:0]     pixIn,
  input  logic                         strobe,
  input  logic                         startRIn,
  output logic                         startROut,
  output logic                         startROe,
  input  logic                         startLIn,
  output logic                         startLOut,
  output logic                         startLOe,
  output logic [CH_COUNT*DOT_BITS-1:0] latchOut
);
  ctrl_t ctrlBus;
  logic  carry;
  logic  startIn;

  assign startIn   = dirRight ? startRIn : startLIn;
  assign startLOe  = dirRight;
  assign startROe  = !dirRight;
  assign startLOut = dirRight && carry;
  assign startROut = !dirRight && carry;

  column_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startIn (startIn),
    .strobe  (strobe),
    .c       (ctrlBus),
    .carry   (carry)
  );

  column_datapath #(
    .CHANNELS (CH_COUNT),
    .BITS     (DOT_BITS),
    .LANES    (DOTS)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .dirRight  (dirRight),
    .pixIn     (pixIn),
    .c         (ctrlBus),
    .latchFlat (latchOut)
  );
endmodule

// File: tb/column_capture_bench.sv
`timescale 1ns/1ps
module column_capture_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dirRight = 1'b1;
  logic [17:0] pixIn = '0;
  logic strobe = 1'b0;
  logic startRIn = 1'b0, startLIn = 1'b0;
  logic startROut, startROe, startLOut, startLOe;
  logic [1439:0] latchOut;

  int vectors = 0;
  int fails = 0;
  bit done = 0;
  logic [5:0] expD [240];
  logic [5:0] expL [240];

  always #2.5 clk = ~clk;

  column_capture u_column_capture (
    .clk(clk), .rstN(rstN), .dirRight(dirRight), .pixIn(pixIn), .strobe(strobe),
    .startRIn(startRIn), .startROut(startROut), .startROe(startROe),
    .startLIn(startLIn), .startLOut(startLOut), .startLOe(startLOe),
    .latchOut(latchOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [17:0] mkPix(input int g, input int salt);
    logic [5:0] r, gg, b;
    r  = 6'((g * 3 + salt) & 63);
    gg = 6'((g * 5 + salt + 1) & 63);
    b  = 6'((g * 7 + salt + 2) & 63);
    return {b, gg, r};
  endfunction

  function automatic void modelWrite(input int g, input logic [17:0] p, input logic dir);
    if (dir) begin
      expD[3*g] = p[5:0]; expD[3*g+1] = p[11:6]; expD[3*g+2] = p[17:12];
    end else begin
      expD[239-3*g] = p[5:0]; expD[238-3*g] = p[11:6]; expD[237-3*g] = p[17:12];
    end
  endfunction

  task automatic checkLatch(input string req);
    int bad = -1;
    for (int k = 0; k < 240; k++)
      if (bad < 0 && latchOut[6*k +: 6] !== expL[k]) bad = k;
    if (bad < 0) chk(1, req, 0, 0);
    else chk(0, {req, " channel mismatch"}, int'(latchOut[6*bad +: 6]), int'(expL[bad]));
  endtask

  task automatic step(input logic [17:0] pix, input logic sIn, input logic stb);
    @(negedge clk);
    pixIn = pix;
    startRIn = dirRight ? sIn : 1'b0;
    startLIn = dirRight ? 1'b0 : sIn;
    strobe = stb;
    @(posedge clk);
    #1;
  endtask

  function automatic logic carryOn();
    return dirRight ? startLOut : startROut;
  endfunction

  function automatic logic otherOut();
    return dirRight ? startROut : startLOut;
  endfunction

  // one line: start at clock 0, optional second start at restartAt
  task automatic runLine(input int n, input int restartAt, input int salt,
                         input bit writes, input logic stb, input string req);
    for (int i = 0; i < n; i++) begin
      logic [17:0] p;
      p = mkPix(i, salt);
      step(p, (i == 0) || (i == restartAt), stb);
      if (writes && i < 80) modelWrite(i, p, dirRight);
      if (i == 78) chk(carryOn() == 1'b0, {req, " R6 carry early"}, int'(carryOn()), 0);
      if (i == 79) begin
        chk(carryOn() == writes, {req, " R6 carry at 80th clock"}, int'(carryOn()), int'(writes));
        chk(otherOut() == 1'b0, {req, " R5 idle port output"}, int'(otherOut()), 0);
      end
      if (i == 80) chk(carryOn() == 1'b0, {req, " R6 carry one clock"}, int'(carryOn()), 0);
    end
  endtask

  task automatic doStrobe(input string req);
    step('0, 1'b0, 1'b1);
    for (int k = 0; k < 240; k++) expL[k] = expD[k];
    step('0, 1'b0, 1'b0);
    checkLatch(req);
  endtask

  task automatic tReset();
    for (int k = 0; k < 240; k++) begin expD[k] = '0; expL[k] = '0; end
    #1;
    checkLatch("R1 latch after reset");
    chk(startROut == 0 && startLOut == 0, "R1 port outputs", int'({startROut, startLOut}), 0);
    rstN = 1'b1;
    step('0, 1'b0, 1'b0);
    chk(startLOe == 1 && startROe == 0, "R5 enables dirRight=1", int'({startLOe, startROe}), 2);
  endtask

  task automatic tUnarmed();
    runLine(82, -1, 1, 0, 1'b0, "R2 unarmed");
    doStrobe("R2 first strobe sees untouched register");
  endtask

  task automatic tForward();
    runLine(85, -1, 7, 1, 1'b0, "R3 forward");
    doStrobe("R3 R7 R8 forward line latched");
  endtask

  task automatic tHeldStrobe();
    step('0, 1'b0, 1'b1);
    for (int k = 0; k < 240; k++) expL[k] = expD[k];
    runLine(81, -1, 13, 1, 1'b1, "R8 held strobe");
    checkLatch("R8 latch unchanged while strobe held");
    step('0, 1'b0, 1'b0);
    doStrobe("R8 next rising edge copies");
  endtask

  task automatic tReverse();
    @(negedge clk);
    dirRight = 1'b0;
    #1;
    chk(startROe == 1 && startLOe == 0, "R5 enables dirRight=0", int'({startROe, startLOe}), 2);
    runLine(83, -1, 50, 1, 1'b0, "R4 reverse");
    doStrobe("R4 reverse line latched");
    @(negedge clk);
    dirRight = 1'b1;
  endtask

  task automatic tAbort();
    runLine(10, -1, 20, 1, 1'b0, "R9 partial");
    doStrobe("R9 partial line latched");
    for (int i = 0; i < 10; i++) step(mkPix(i, 33), 1'b0, 1'b0);
    doStrobe("R9 idle pointer writes nothing");
    runLine(81, -1, 30, 1, 1'b0, "R9 restart");
    doStrobe("R9 fresh start at group 0");
  endtask

  task automatic tRestartIgnored();
    runLine(81, 5, 40, 1, 1'b0, "R10 second start");
    doStrobe("R10 start mid-line ignored");
  endtask

  initial begin
    tReset();
    tUnarmed();
    tForward();
    tHeldStrobe();
    tReverse();
    tAbort();
    tRestartIgnored();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      fails++;
      vectors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule